// File: doc/BRIEF.md
# Crosspoint Read Sequencer with Background-Sample Reuse

This block sequences reads from a resistive crosspoint array that has no access transistor per cell. Each read has two steps. In the first step every unselected line, and the selected word line as well, sits at half the read voltage. A sample-and-hold stage captures the leakage current that flows along the selected column. In the second step the selected word line goes to the full read voltage and the total current is sensed. The stored cell value depends on how much the total current exceeds the held leakage current. The analog compare sits outside this block and returns one result bit.

The block remembers the column that its held sample came from. A read of that same column skips the first step and costs only the read-phase cycles. A read of any other column costs the background cycles plus the read cycles. The held sample stops being trusted in two cases: after a write to its column, and after a retention window counted in cycles.

Requests use a valid/ready handshake, and only one request is in flight at a time. The response also uses a valid/ready handshake. The block counts column hits and column misses.

Top module: `xrs_top`

## Requirements
- R1: After reset the block shows req_ready=1, rsp_valid=0, every analog strobe low and both counters at zero, and it holds no background sample, so the first read is a miss.
- R2: On a miss the block holds bias_half and sh_track high for exactly T_BG cycles, with wl_full low, before the read phase starts.
- R3: The read phase holds bias_half and wl_full high for T_RD cycles. sense_en is high only in the last of those cycles, and rsp_bit returns the value of sense_bit sampled in that cycle.
- R4: A read whose column equals the held column while the sample is valid skips the background phase. rsp_valid then rises T_RD clock edges after the accepting edge, and it rises T_BG+T_RD edges after that edge on a miss. rsp_hit reports 1 for a hit and 0 for a miss.
- R5: The held column is replaced when a background phase ends, so a read of a different column is a miss and becomes the new held column.
- R6: A write notice (wr_en) whose wr_col equals the held column invalidates the sample. A write notice for any other column has no effect.
- R7: The held sample remains valid for RETAIN cycles after it is captured and is invalid after that.
- R8: req_ready is low from the accepting edge until the response has been taken.
- R9: While rsp_valid=1 and rsp_ready=0, rsp_valid stays high and rsp_bit and rsp_hit stay unchanged.
- R10: Each accepted request adds one to exactly one of hit_cnt or miss_cnt.
- R11: sel_row and sel_col show the accepted address and stay stable through both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_row | input | ROW_W | Word line of the read |
| req_col | input | COL_W | Bit line of the read |
| wr_en | input | 1 | A write to wr_col has taken place |
| wr_col | input | COL_W | Column that was written |
| sense_bit | input | 1 | Result of the analog compare |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_valid | output | 1 | Response available |
| rsp_bit | output | 1 | Cell value that was read |
| rsp_hit | output | 1 | The read reused the held background sample |
| sel_row | output | ROW_W | Selected word line driven to the array |
| sel_col | output | COL_W | Selected bit line driven to the array |
| bias_half | output | 1 | Half-voltage bias on the array lines |
| wl_full | output | 1 | Full read voltage on the selected word line |
| sh_track | output | 1 | Sample-and-hold tracks the background current |
| sense_en | output | 1 | Strobe for the sense comparator |
| hit_cnt | output | CNT_W | Count of column hits |
| miss_cnt | output | CNT_W | Count of column misses |

## Verification
The bench builds the block with T_BG=3 and T_RD=2. With these values the latency gap between a hit and a miss (five edges against two) is easy to tell apart, and a read phase lasts more than one cycle, so a misplaced sense strobe shows up. RETAIN=40 makes the retention expiry reachable after a short idle gap, while back-to-back reads still stay well inside the window. An 8-bit counter width and 3-bit column addresses keep the hit and miss totals and the column compares small enough to check directly.

// File: rtl/xrs_pkg.sv
// Shared types for the crosspoint read sequencer.
package xrs_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BG   = 2'd1,
        PH_RD   = 2'd2,
        PH_RSP  = 2'd3
    } xrs_phase_e;
endpackage

// File: rtl/xrs_phase_ctl.sv
// Phase controller: steps through idle, background, read and response.
// Assumes T_BG >= 1 and T_RD >= 1. 'start' is only asserted in PH_IDLE.
module xrs_phase_ctl
    import xrs_pkg::*;
#(
    parameter int T_BG = 3,
    parameter int T_RD = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       skip_bg,
    input  logic       rsp_take,
    output xrs_phase_e phase,
    output logic       last
);
    localparam int MAXT = (T_BG > T_RD) ? T_BG : T_RD;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] BG_LOAD = CW'(T_BG - 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(T_RD - 1);

    logic [CW-1:0] cnt;

    // Last cycle of a timed phase.
    always_comb last = ((phase == PH_BG) || (phase == PH_RD)) && (cnt == '0);

    // Phase register and down-counter for the timed phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= skip_bg ? PH_RD : PH_BG;
                    cnt   <= skip_bg ? RD_LOAD : BG_LOAD;
                end
                PH_BG: if (cnt == '0) begin
                    phase <= PH_RD;
                    cnt   <= RD_LOAD;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_RD: if (cnt == '0) begin
                    phase <= PH_RSP;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_RSP: if (rsp_take) begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xrs_bg_tag.sv
// Background-sample tag: records which column the held sample belongs to,
// and drops it on a write to that column or when the retention window ends.
// Assumes RETAIN >= 2. A write on the same edge as a capture takes priority.
module xrs_bg_tag #(
    parameter int COL_W  = 3,
    parameter int RETAIN = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [COL_W-1:0] cap_col,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic [COL_W-1:0] look_col,
    output logic             hit
);
    localparam int AW = $clog2(RETAIN + 1);
    localparam logic [AW-1:0] AGE_LAST = AW'(RETAIN - 1);

    logic             valid;
    logic [COL_W-1:0] tag;
    logic [AW-1:0]    age;

    // Lookup against the held column.
    always_comb hit = valid && (tag == look_col);

    // Tag, validity and age tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            age   <= '0;
        end else if (capture) begin
            tag   <= cap_col;
            age   <= '0;
            valid <= !(wr_en && (wr_col == cap_col));
        end else if (valid) begin
            if ((wr_en && (wr_col == tag)) || (age == AGE_LAST)) begin
                valid <= 1'b0;
            end else begin
                age <= age + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xrs_stats.sv
// Hit and miss counters, advanced once per accepted request. Wrap on overflow.
module xrs_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             hit,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    // Count the outcome of every accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_cnt  <= '0;
            miss_cnt <= '0;
        end else if (acc) begin
            if (hit) hit_cnt  <= hit_cnt + 1'b1;
            else     miss_cnt <= miss_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/xrs_top.sv
// Crosspoint read sequencer: for each read it runs an optional background
// phase and then a read phase, and it skips the background phase when the
// held sample belongs to the requested column. One request at a time.
// Assumes the sense comparator result is valid in the last read cycle.
module xrs_top
    import xrs_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 3,
    parameter int T_BG   = 3,
    parameter int T_RD   = 2,
    parameter int RETAIN = 1000,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             wr_en,
    input  logic [COL_W-1:0] wr_col,
    input  logic             sense_bit,
    input  logic             rsp_ready,
    output logic             rsp_valid,
    output logic             rsp_bit,
    output logic             rsp_hit,
    output logic [ROW_W-1:0] sel_row,
    output logic [COL_W-1:0] sel_col,
    output logic             bias_half,
    output logic             wl_full,
    output logic             sh_track,
    output logic             sense_en,
    output logic [CNT_W-1:0] hit_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    xrs_phase_e phase;
    logic       last;
    logic       accept;
    logic       tag_hit;
    logic       capture;

    // Handshake and strobe decode.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        rsp_valid = (phase == PH_RSP);
        accept    = req_valid && req_ready;
        bias_half = (phase == PH_BG) || (phase == PH_RD);
        wl_full   = (phase == PH_RD);
        sh_track  = (phase == PH_BG);
        sense_en  = (phase == PH_RD) && last;
        capture   = (phase == PH_BG) && last;
    end

    xrs_phase_ctl #(.T_BG(T_BG), .T_RD(T_RD)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .skip_bg  (tag_hit),
        .rsp_take (rsp_ready),
        .phase    (phase),
        .last     (last)
    );

    xrs_bg_tag #(.COL_W(COL_W), .RETAIN(RETAIN)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .cap_col  (sel_col),
        .wr_en    (wr_en),
        .wr_col   (wr_col),
        .look_col (req_col),
        .hit      (tag_hit)
    );

    xrs_stats #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (accept),
        .hit      (tag_hit),
        .hit_cnt  (hit_cnt),
        .miss_cnt (miss_cnt)
    );

    // Address latch on accept; result latch on the sense strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_row <= '0;
            sel_col <= '0;
            rsp_bit <= 1'b0;
            rsp_hit <= 1'b0;
        end else begin
            if (accept) begin
                sel_row <= req_row;
                sel_col <= req_col;
                rsp_hit <= tag_hit;
            end
            if (sense_en) rsp_bit <= sense_bit;
        end
    end
endmodule

// File: rtl/xrs_chk.sv
// Protocol checker for xrs_top, attached with bind.
module xrs_chk #(
    parameter int COL_W = 3,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_ready,
    input logic             rsp_valid,
    input logic             rsp_bit,
    input logic             rsp_hit,
    input logic [COL_W-1:0] sel_col,
    input logic             bias_half,
    input logic             wl_full,
    input logic             sh_track,
    input logic             sense_en,
    input logic [CNT_W-1:0] hit_cnt,
    input logic [CNT_W-1:0] miss_cnt
);
    // R2: the background phase never overlaps the full-voltage drive
    a_r2_no_full_in_bg: assert property (@(posedge clk) disable iff (!rst_n)
        sh_track |-> (!wl_full && bias_half));

    // R3: the sense strobe only fires while the full read bias is applied
    a_r3_sense_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> (wl_full && bias_half));

    // R8: no new request is accepted while a read or its response is pending
    a_r8_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_track || wl_full || rsp_valid) |-> !req_ready);

    // R9: a stalled response holds its value
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_bit) && $stable(rsp_hit)));

    // R10: exactly one counter moves per accepted request
    a_r10_one_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((hit_cnt != $past(hit_cnt)) != (miss_cnt != $past(miss_cnt))));

    // R11: the selected column is stable across consecutive phase cycles
    a_r11_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bias_half && $past(bias_half)) |-> $stable(sel_col));
endmodule

bind xrs_top xrs_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_bit   (rsp_bit),
    .rsp_hit   (rsp_hit),
    .sel_col   (sel_col),
    .bias_half (bias_half),
    .wl_full   (wl_full),
    .sh_track  (sh_track),
    .sense_en  (sense_en),
    .hit_cnt   (hit_cnt),
    .miss_cnt  (miss_cnt)
);

// File: tb/sim_xrs_top.sv
// Bench for xrs_top: a vector table of reads, then directed tests.
module sim_xrs_top;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 3;
    localparam int T_BG   = 3;
    localparam int T_RD   = 2;
    localparam int RETAIN = 40;
    localparam int CNT_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             wr_en = 1'b0;
    logic [COL_W-1:0] wr_col = '0;
    logic             sense_bit = 1'b0;
    logic             rsp_ready = 1'b1;
    logic             rsp_valid;
    logic             rsp_bit;
    logic             rsp_hit;
    logic [ROW_W-1:0] sel_row;
    logic [COL_W-1:0] sel_col;
    logic             bias_half;
    logic             wl_full;
    logic             sh_track;
    logic             sense_en;
    logic [CNT_W-1:0] hit_cnt;
    logic [CNT_W-1:0] miss_cnt;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xrs_top #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_BG(T_BG), .T_RD(T_RD),
        .RETAIN(RETAIN), .CNT_W(CNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .wr_en(wr_en), .wr_col(wr_col),
        .sense_bit(sense_bit), .rsp_ready(rsp_ready), .rsp_valid(rsp_valid),
        .rsp_bit(rsp_bit), .rsp_hit(rsp_hit), .sel_row(sel_row), .sel_col(sel_col),
        .bias_half(bias_half), .wl_full(wl_full), .sh_track(sh_track),
        .sense_en(sense_en), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One read; called and returns on a negedge with the block idle.
    task automatic rd(input int row, input int col, input bit sense, input bit exp_hit);
        int lat = 0;
        int bgc = 0;
        int sen = 0;
        chk("R8 ready before request", int'(req_ready), 1);
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        sense_bit = sense;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 ready low after accept", int'(req_ready), 0);
        chk("R11 sel_row", int'(sel_row), row);
        chk("R11 sel_col", int'(sel_col), col);
        while (!rsp_valid && lat < 100) begin
            if (sh_track) bgc++;
            if (sense_en) begin
                sen++;
                chk("R3 full bias at sense", int'(wl_full), 1);
            end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk("R4 latency", lat, exp_hit ? T_RD : T_BG + T_RD);
        chk("R2 background cycles", bgc, exp_hit ? 0 : T_BG);
        chk("R3 single sense strobe", sen, 1);
        chk("R3 rsp_bit", int'(rsp_bit), int'(sense));
        chk("R4 rsp_hit", int'(rsp_hit), int'(exp_hit));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int col);
        wr_col = COL_W'(col);
        wr_en  = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
    endtask

    // Vector: {exp_hit, sense, col[2:0], row[3:0]}
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 1'b1, 3'd2, 4'd1},
        {1'b1, 1'b0, 3'd2, 4'd5},
        {1'b1, 1'b1, 3'd2, 4'd0},
        {1'b0, 1'b0, 3'd5, 4'd3},
        {1'b0, 1'b1, 3'd2, 4'd3},
        {1'b0, 1'b1, 3'd7, 4'd15},
        {1'b1, 1'b0, 3'd7, 4'd2},
        {1'b0, 1'b0, 3'd0, 4'd0},
        {1'b1, 1'b1, 3'd0, 4'd9}
    };

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 strobes", int'({bias_half, wl_full, sh_track, sense_en}), 0);
        chk("R1 hit_cnt", int'(hit_cnt), 0);
        chk("R1 miss_cnt", int'(miss_cnt), 0);
        rst_n = 1'b1;
        idle(2);

        // R4 R5: table walk (first read misses per R1)
        for (int i = 0; i < NV; i++) begin
            rd(int'(VEC[i][3:0]), int'(VEC[i][6:4]), VEC[i][7], VEC[i][8]);
            idle(1);
        end
        // R10: counters after table
        chk("R10 hit_cnt", int'(hit_cnt), 4);
        chk("R10 miss_cnt", int'(miss_cnt), 5);

        // R6: write elsewhere has no effect, write to held column invalidates
        wr(3);
        rd(4, 0, 1'b1, 1'b1);
        wr(0);
        rd(4, 0, 1'b0, 1'b0);

        // R7: within window hits, after window misses
        idle(5);
        rd(1, 0, 1'b1, 1'b1);
        idle(RETAIN + 10);
        rd(1, 0, 1'b0, 1'b0);

        // R9 R8: response backpressure
        rsp_ready = 1'b0;
        req_row = 4'd6; req_col = 3'd0; sense_bit = 1'b1; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        sense_bit = 1'b1;
        idle(T_RD + 1);
        chk("R9 rsp_valid held", int'(rsp_valid), 1);
        chk("R9 rsp_hit", int'(rsp_hit), 1);
        sense_bit = 1'b0;
        idle(5);
        chk("R9 rsp_valid still held", int'(rsp_valid), 1);
        chk("R9 rsp_bit stable", int'(rsp_bit), 1);
        chk("R8 ready low while pending", int'(req_ready), 0);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R9 rsp taken", int'(rsp_valid), 0);
        chk("R8 ready after take", int'(req_ready), 1);

        // R10: final totals
        chk("R10 hit_cnt final", int'(hit_cnt), 7);
        chk("R10 miss_cnt final", int'(miss_cnt), 7);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule